// File: doc/BRIEF.md
# Serial Setting Register Front End

This block connects a three-wire serial link to a set of 8-bit output setting registers. Each register has a stored default supplied on an input bus by a separate storage sequencer. While the select line is high, the host clocks in frames. A frame is a start bit, a channel address and a data byte. While the new byte shifts in, the old contents of the addressed register shift out on a data output with a separate output enable. Every frame therefore reads the register and then overwrites it. To read without changing a setting, the host lets the select drop, which restores all registers from their stored defaults.

The serial clock, select and data input are sampled by a faster system clock through synchronisers. All framing runs on detected rising edges of the serial clock. A low pulse on select must last a set number of system-clock samples before it is taken as a drop, so short glitches do not discard temporary settings. Reset loads every working register from its stored default without any serial clock activity.

Top module: `serial_setting_if`

## Requirements
- R1: While rstN is low at a system clock edge, each working register loads its stored default. Right after reset, settingVals equals storedVals.
- R2: A frame is sent on the rising edges of the serial clock, in this order: a logic-1 start bit, address bit A0, address bit A1, then data bits D0 to D7 (least significant first). A sdi level of 0 while no frame is in progress is ignored.
- R3: The address value {A1,A0} = 2'b10 selects channel 0 (settingVals[7:0]). The value 2'b11 selects channel 1 (settingVals[15:8]). The other channel keeps its value.
- R4: During a valid frame, bit i of the addressed register's previous contents is present on sdoData just before the rising edge that carries Di, for i = 0 to 7.
- R5: The addressed setting does not change on the rising edge that carries D7. It takes the received byte on the next rising edge of the serial clock.
- R6: Address values 2'b00 and 2'b01 complete a normal-length frame but change no setting, and sdoData stays 0 throughout.
- R7: The two rising edges that follow D7 never start a frame, whatever sdi is. A start bit on the third edge is accepted.
- R8: sdoOe follows the filtered select. While sdoOe is low, sdoData is 0.
- R9: When the filtered select falls, both working registers reload from storedVals and any frame in progress is abandoned.
- R10: A select low pulse shorter than DEGLITCH system-clock samples causes no reload, and a frame in progress continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Synchronous active-low reset; loads the stored defaults |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sel | input | 1 | Frame select, active high |
| sdi | input | 1 | Serial data input |
| storedVals | input | NUM_CH*DATA_W | Stored default per channel, channel 0 in the low byte |
| settingVals | output | NUM_CH*DATA_W | Current working setting per channel |
| sdoData | output | 1 | Serial data output value |
| sdoOe | output | 1 | Output enable for sdoData; low means the line is released |

## Verification
The assertions check on every cycle that a falling output enable coincides with both settings equal to the stored defaults, and that sdoData is 0 whenever the enable is low. They also check that, with select held, a setting changes only on a commit strobe, that a commit and a reload never fire together, and that the first cycle after reset shows the stored defaults. The bench scenarios are needed for the bit order of the readout, the one-edge commit delay, address decoding, the ignored gap edges, the aborted frame and the tolerated glitch. Each of these depends on a sequence of serial edges that a single-cycle property cannot express.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_COMMIT,
    PH_GAP
  } phase_t;

  typedef struct packed {
    logic addrShift;
    logic loadOut;
    logic dataShift;
    logic commit;
    logic reload;
    logic outPhase;
  } strobe_t;

endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], din};
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/sws_ctrl.sv
module sws_ctrl
  import sws_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int DEGLITCH    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    sel,
  input  logic    sdi,
  output logic    sdiS,
  output logic    selFilt,
  output strobe_t strb
);
  localparam int MAX_BITS = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W    = $clog2(MAX_BITS) + 1;
  localparam int DG_W     = $clog2(DEGLITCH) + 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [DG_W-1:0]  DG_LAST   = DG_W'(DEGLITCH - 1);

  logic [2:0] syncOut;
  logic sclkS, selS, sclkPrev, sclkRise;
  logic [DG_W-1:0] lowCnt;
  logic reloadNow;
  phase_t phase, phaseNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  sws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din({sdi, sel, sclk}), .dout(syncOut)
  );
  assign {sdiS, selS, sclkS} = syncOut;

  always_ff @(posedge clk) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end
  assign sclkRise = sclkS & ~sclkPrev;

  // select deglitch: a drop counts only after DEGLITCH consecutive low samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selFilt <= 1'b0;
      lowCnt  <= '0;
    end else if (selS) begin
      selFilt <= 1'b1;
      lowCnt  <= '0;
    end else if (selFilt) begin
      if (lowCnt == DG_LAST) begin
        selFilt <= 1'b0;
        lowCnt  <= '0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end
  assign reloadNow = selFilt && !selS && (lowCnt == DG_LAST);

  always_comb begin
    strb       = '0;
    phaseNext  = phase;
    bitCntNext = bitCnt;
    if (reloadNow) begin
      strb.reload = 1'b1;
      phaseNext   = PH_IDLE;
      bitCntNext  = '0;
    end else if (!selFilt) begin
      phaseNext  = PH_IDLE;
      bitCntNext = '0;
    end else if (sclkRise) begin
      unique case (phase)
        PH_IDLE: begin
          if (sdiS) begin
            phaseNext  = PH_ADDR;
            bitCntNext = '0;
          end
        end
        PH_ADDR: begin
          strb.addrShift = 1'b1;
          if (bitCnt == ADDR_LAST) begin
            strb.loadOut = 1'b1;
            phaseNext    = PH_DATA;
            bitCntNext   = '0;
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end
        PH_DATA: begin
          strb.dataShift = 1'b1;
          if (bitCnt == DATA_LAST) begin
            phaseNext  = PH_COMMIT;
            bitCntNext = '0;
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end
        PH_COMMIT: begin
          strb.commit = 1'b1;
          phaseNext   = PH_GAP;
        end
        PH_GAP:    phaseNext = PH_IDLE;
        default:   phaseNext = PH_IDLE;
      endcase
    end
    strb.outPhase = selFilt && (phase == PH_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
    end else begin
      phase  <= phaseNext;
      bitCnt <= bitCntNext;
    end
  end
endmodule

// File: rtl/sws_datapath.sv
module sws_datapath
  import sws_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic                          sdiS,
  input  logic [NUM_CH-1:0][DATA_W-1:0] storedVals,
  output logic [NUM_CH-1:0][DATA_W-1:0] settingVals,
  output logic                          sdoData
);
  localparam int CODE_BASE = 1 << (ADDR_W - 1);

  logic [ADDR_W-1:0] addrReg, addrNext;
  logic [DATA_W-1:0] shiftReg, readVal;
  logic [NUM_CH-1:0] hitLoad, hitCommit;

  assign addrNext = {sdiS, addrReg[ADDR_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN)               addrReg <= '0;
    else if (strb.addrShift) addrReg <= addrNext;
  end

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      localparam logic [ADDR_W-1:0] CODE = ADDR_W'(CODE_BASE + k);
      assign hitLoad[k]   = (addrNext == CODE);
      assign hitCommit[k] = (addrReg == CODE);

      always_ff @(posedge clk) begin
        if (!rstN)                           settingVals[k] <= storedVals[k];
        else if (strb.reload)                settingVals[k] <= storedVals[k];
        else if (strb.commit && hitCommit[k]) settingVals[k] <= shiftReg;
      end
    end
  endgenerate

  always_comb begin
    readVal = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (hitLoad[k]) readVal = readVal | settingVals[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               shiftReg <= '0;
    else if (strb.loadOut)   shiftReg <= readVal;
    else if (strb.dataShift) shiftReg <= {sdiS, shiftReg[DATA_W-1:1]};
  end

  assign sdoData = strb.outPhase & shiftReg[0];
endmodule

// File: rtl/serial_setting_if.sv
module serial_setting_if
  import sws_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int DEGLITCH    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclk,
  input  logic                          sel,
  input  logic                          sdi,
  input  logic [NUM_CH-1:0][DATA_W-1:0] storedVals,
  output logic [NUM_CH-1:0][DATA_W-1:0] settingVals,
  output logic                          sdoData,
  output logic                          sdoOe
);
  strobe_t strb;
  logic    sdiS;
  logic    selFilt;

  sws_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DEGLITCH(DEGLITCH), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sel(sel), .sdi(sdi),
    .sdiS(sdiS), .selFilt(selFilt), .strb(strb)
  );

  sws_datapath #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiS(sdiS),
    .storedVals(storedVals), .settingVals(settingVals), .sdoData(sdoData)
  );

  assign sdoOe = selFilt;
endmodule

// File: rtl/serial_setting_if_chk.sv
module serial_setting_if_chk #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          sdoOe,
  input logic                          sdoData,
  input logic [NUM_CH-1:0][DATA_W-1:0] settingVals,
  input logic [NUM_CH-1:0][DATA_W-1:0] storedVals,
  input logic                          commitStb,
  input logic                          reloadStb
);
  // R1
  power_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> settingVals == $past(storedVals));

  // R9
  reload_on_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdoOe) |-> settingVals == $past(storedVals));

  // R8
  quiet_when_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoOe |-> !sdoData);

  // R5
  change_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && $past(sdoOe) && !$stable(settingVals)) |-> $past(commitStb));

  // R9
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commitStb, reloadStb}));
endmodule

bind serial_setting_if serial_setting_if_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sdoOe(sdoOe), .sdoData(sdoData),
  .settingVals(settingVals), .storedVals(storedVals),
  .commitStb(strb.commit), .reloadStb(strb.reload)
);

// File: tb/serial_setting_if_tb.sv
module serial_setting_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic sel = 1'b0;
  logic sdi = 1'b0;
  logic [1:0][7:0] storedVals;
  logic [1:0][7:0] settingVals;
  logic sdoData, sdoOe;

  logic [7:0] curM [2];
  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_setting_if u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sel(sel), .sdi(sdi),
    .storedVals(storedVals), .settingVals(settingVals),
    .sdoData(sdoData), .sdoOe(sdoOe)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clkBit(input logic b, output logic s);
    @(negedge clk);
    sdi = b;
    repeat (HALF) @(negedge clk);
    s = sdoData;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic glitch();
    @(negedge clk);
    sel = 1'b0;
    repeat (2) @(negedge clk);
    sel = 1'b1;
  endtask

  function automatic int chanOf(input logic [1:0] a);
    if (a == 2'b10) return 0;
    if (a == 2'b11) return 1;
    return -1;
  endfunction

  task automatic checkSettings(input string req);
    chk(settingVals[0] == curM[0], req, {8'h0, settingVals[0]}, {8'h0, curM[0]});
    chk(settingVals[1] == curM[1], req, {8'h0, settingVals[1]}, {8'h0, curM[1]});
  endtask

  task automatic doFrame(input logic [1:0] a, input logic [7:0] d, input int idle,
                         input logic gapBit, input int glitchAt);
    logic s;
    logic [7:0] rd;
    logic [10:0] seq;
    int ch;
    logic [7:0] expRd;
    ch = chanOf(a);
    expRd = (ch >= 0) ? curM[ch] : 8'h00;
    seq = {d, a[1], a[0], 1'b1};
    rd = '0;
    for (int i = 0; i < idle; i++) clkBit(1'b0, s);
    for (int i = 0; i < 11; i++) begin
      if (i == glitchAt) glitch();
      clkBit(seq[i], s);
      if (i >= 3) rd[i-3] = s;
    end
    if (ch >= 0) chk(rd == expRd, "R4 readout", {8'h0, rd}, {8'h0, expRd});
    else         chk(rd == expRd, "R6 readout zero", {8'h0, rd}, {8'h0, expRd});
    checkSettings("R5 no change on D7 edge");
    clkBit(1'b0, s);
    if (ch >= 0) curM[ch] = d;
    if (ch >= 0) checkSettings("R3 R5 commit");
    else         checkSettings("R6 no change");
    clkBit(gapBit, s);
  endtask

  task automatic dropSel(input logic [7:0] newA, input logic [7:0] newB);
    @(negedge clk);
    sel = 1'b0;
    repeat (12) @(negedge clk);
    chk(sdoOe == 1'b0, "R8 released", {15'h0, sdoOe}, 16'h0);
    chk(sdoData == 1'b0, "R8 data zero", {15'h0, sdoData}, 16'h0);
    curM[0] = storedVals[0];
    curM[1] = storedVals[1];
    checkSettings("R9 reload");
    storedVals[0] = newA;
    storedVals[1] = newB;
    repeat (2) @(negedge clk);
    sel = 1'b1;
    repeat (8) @(negedge clk);
    chk(sdoOe == 1'b1, "R8 enabled", {15'h0, sdoOe}, 16'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic s;
    int r;
    logic [1:0] a;
    void'($urandom(32'd1234));
    storedVals[0] = 8'h3C;
    storedVals[1] = 8'hC3;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curM[0] = 8'h3C;
    curM[1] = 8'hC3;
    checkSettings("R1 power-on load");
    chk(sdoOe == 1'b0, "R8 reset released", {15'h0, sdoOe}, 16'h0);

    sel = 1'b1;
    repeat (8) @(negedge clk);
    chk(sdoOe == 1'b1, "R8 enabled", {15'h0, sdoOe}, 16'h1);

    // R2 R3 R4 R5: channel 0 write, leading idle zeros ignored
    doFrame(2'b10, 8'h96, 3, 1'b0, -1);
    // R7: gap edge with sdi high, next frame immediately after
    doFrame(2'b11, 8'h11, 0, 1'b1, -1);
    doFrame(2'b11, 8'h5A, 0, 1'b0, -1);
    // R6: unused codes
    doFrame(2'b00, 8'hFF, 2, 1'b0, -1);
    doFrame(2'b01, 8'hA5, 2, 1'b0, -1);
    // R10: short glitch mid-frame
    doFrame(2'b10, 8'h42, 2, 1'b0, 5);
    checkSettings("R10 no reload after glitch");

    // R9: abort a frame part way
    clkBit(1'b1, s); clkBit(1'b0, s); clkBit(1'b1, s);
    for (int i = 0; i < 5; i++) clkBit(1'b1, s);
    dropSel(8'h3C, 8'hC3);
    doFrame(2'b10, 8'h77, 2, 1'b0, -1);

    for (int it = 0; it < 50; it++) begin
      r = $urandom % 10;
      a = 2'($urandom);
      if (r == 0) dropSel(8'($urandom), 8'($urandom));
      doFrame(a, 8'($urandom), 2 + ($urandom % 2), 1'($urandom),
              (r == 1) ? 3 + int'($urandom % 8) : -1);
    end
    dropSel(8'h00, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule